// File: doc/BRIEF.md
# Serial Channel-Select Controller with Pass-Through

This block is the digital core of a serially programmed eight-way switch array. A host shifts a four-bit command in over a serial clock and data line while chip select is high. When chip select drops, the block first turns every switch off, waits a programmable number of system clock cycles, and then closes the one switch named by the command. If the command's enable bit is clear, no switch closes. The chosen switch stays closed for as long as chip select is low. When chip select rises again, the switch opens after a second programmable delay.

The same four-bit shift register also acts as a delay line to a downstream device, so several controllers can share one serial port. While chip select is high, the bit shifted in four serial clock edges earlier is driven onto the downstream data line. While chip select is low, the direction reverses: the downstream line is passed straight back to the upstream line through logic only, with no register in the path. The serial clock, chip select and upstream data are brought into the system clock domain through two-flop synchronisers. The bidirectional lines appear at the ports as separate in, out and output-enable signals.

Top module: `chsel_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until chip select is first seen high, all switch enables are 0, both output enables are 0 and `dn_out` is 0.
- R2: While chip select is high, each rising serial clock edge shifts `up_in` into the command register. The first bit is the enable bit, followed by the index bits MSB first. When more than four bits arrive in one frame, the last four define the command.
- R3: When the enable bit (command bit 3) is 1, only switch number {B2,B1,B0} (command bits 2..0, binary) is enabled; 000 selects `sw_en[0]` and 111 selects `sw_en[7]`. When the enable bit is 0, no switch is enabled.
- R4: Counting as edge 1 the first system clock edge after chip select falls at the port, all switch enables are 0 from edge 3 on. The selected switch turns on at edge T_ON+3 and not before.
- R5: The switch enables do not change while chip select stays low. After chip select rises, the active switch turns off at edge T_OFF+3, counted the same way.
- R6: While chip select is high (from edge 3 after its rise), `dn_oe`=1 and `up_oe`=0. `dn_out` carries the bit that was shifted in four rising serial clock edges earlier.
- R7: While chip select is low after a frame (from edge 3 after its fall), `up_oe`=1 and `dn_oe`=0, and `up_out` equals `dn_in` with no clock delay.
- R8: At most one switch enable is high at any time. A change from one enabled switch to another always passes through at least one cycle with all enables low.
- R9: Serial clock edges while chip select is low leave the command register unchanged. A later frame carrying no bits therefore re-selects the previous command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial interface |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial clock |
| sel_in | input | 1 | Chip select, high while a command is shifted in |
| up_in | input | 1 | Upstream data line, input side |
| up_out | output | 1 | Upstream data line, output side (pass-back of `dn_in`) |
| up_oe | output | 1 | Upstream data line output enable |
| dn_in | input | 1 | Downstream data line, input side |
| dn_out | output | 1 | Downstream data line, output side (shift register tail) |
| dn_oe | output | 1 | Downstream data line output enable |
| sw_en | output | 8 | One enable per analog switch |

## Verification
A wrong bit in the command register shows on `dn_out` within four serial clock edges. It also shows as the wrong switch, or a missing switch, T_ON+3 cycles after chip select falls. A sequencer stuck in its arming or draining state shows as an enable edge in the wrong cycle, or as an enable that never drops. For that reason the bench measures the exact cycle of every switch edge, and not only the value the switches settle to. A wrong direction state shows at once on the output enables, and a stray register in the pass-back path shows as `up_out` lagging `dn_in`.

// File: rtl/chsel_pkg.sv
// Shared types for the serial channel-select controller.
package chsel_pkg;

    // Switch sequencer phases
    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,   // all switches open, nothing pending
        SW_ARM   = 2'd1,   // all open, counting the turn-on delay
        SW_LIVE  = 2'd2,   // selected switch closed
        SW_DRAIN = 2'd3    // selected switch still closed, counting turn-off delay
    } sw_state_t;

    // Data line direction
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,   // nothing driven (after reset)
        DIR_FWD  = 2'd1,   // upstream in, downstream driven from shift register
        DIR_REV  = 2'd2    // downstream in, upstream driven from downstream
    } dir_t;

endpackage

// File: rtl/chsel_sync.sv
// Two-flop synchroniser, one chain per bit.
// Assumes each input bit is independent; no multi-bit coherency is provided.
module chsel_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_chain
            logic stage1, stage2;
            // Capture the asynchronous bit and let it settle one cycle
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1 <= 1'b0;
                    stage2 <= 1'b0;
                end else begin
                    stage1 <= d_async[g];
                    stage2 <= stage1;
                end
            end
            assign d_sync[g] = stage2;
        end
    endgenerate
endmodule

// File: rtl/chsel_shreg.sv
// Command shift register. Shifts on request, new bit entering at the LSB,
// so after W shifts the first bit sits at the MSB and feeds the tail output.
module chsel_shreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         tail
);
    logic [W-1:0] sr_q;

    // Shift one bit in per request
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (shift_en)
            sr_q <= {sr_q[W-2:0], din};
    end

    assign word = sr_q;
    assign tail = sr_q[W-1];

    // R2: every shift moves old content up by one and takes din at the bottom
    a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr_q[W-1:1] == $past(sr_q[W-2:0])) && (sr_q[0] == $past(din)));

endmodule

// File: rtl/chsel_switch_seq.sv
// Switch sequencer. On a select fall it latches the command, opens every
// switch, waits ON_DLY cycles, then closes the decoded switch. On a select
// rise it keeps the switch closed OFF_DLY more cycles, then opens it.
// Assumes sel_fall and sel_rise are single-cycle pulses that never coincide.
module chsel_switch_seq
    import chsel_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int ON_DLY = 6,
    parameter int OFF_DLY = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_fall,
    input  logic                    sel_rise,
    input  logic [$clog2(N_CH):0]   cmd,
    output logic [N_CH-1:0]         sw_en
);
    localparam int IDX_W  = $clog2(N_CH);
    localparam int CMD_W  = IDX_W + 1;
    localparam int ON_CNT = (ON_DLY  < 1) ? 1 : ON_DLY;
    localparam int OFF_CNT = (OFF_DLY < 1) ? 1 : OFF_DLY;
    localparam int MAX_CNT = (ON_CNT > OFF_CNT) ? ON_CNT : OFF_CNT;
    localparam int CNT_W  = $clog2(MAX_CNT + 1);

    sw_state_t        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CMD_W-1:0] cmd_q;
    logic [N_CH-1:0]  sw_q;
    logic [N_CH-1:0]  decoded;

    // One-hot decode of the latched command, gated by its enable bit
    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_dec
            assign decoded[g] = cmd_q[CMD_W-1] && (cmd_q[IDX_W-1:0] == IDX_W'(g));
        end
    endgenerate

    // Phase, delay counter and switch register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            cnt_q   <= '0;
            cmd_q   <= '0;
            sw_q    <= '0;
        end else if (sel_fall) begin
            cmd_q   <= cmd;
            sw_q    <= '0;
            cnt_q   <= CNT_W'(ON_CNT - 1);
            state_q <= SW_ARM;
        end else begin
            case (state_q)
                SW_ARM: begin
                    if (sel_rise)
                        state_q <= SW_IDLE;
                    else if (cnt_q == '0) begin
                        sw_q    <= decoded;
                        state_q <= SW_LIVE;
                    end else
                        cnt_q <= cnt_q - 1'b1;
                end
                SW_LIVE: begin
                    if (sel_rise) begin
                        cnt_q   <= CNT_W'(OFF_CNT - 1);
                        state_q <= SW_DRAIN;
                    end
                end
                SW_DRAIN: begin
                    if (cnt_q == '0) begin
                        sw_q    <= '0;
                        state_q <= SW_IDLE;
                    end else
                        cnt_q <= cnt_q - 1'b1;
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end

    assign sw_en = sw_q;

    // R8: never more than one switch closed
    a_r8_single_switch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_q));

    // R8: a closed switch may only be followed by itself or by all-open
    a_r8_break_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_q != '0) && ($past(sw_q) != '0)) |-> (sw_q == $past(sw_q)));

    // R4: nothing is closed while the turn-on delay runs
    a_r4_dark_while_arming: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_ARM) |-> (sw_q == '0));

    // R5: the closed switch holds through the live phase
    a_r5_hold_while_live: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SW_LIVE) && ($past(state_q) == SW_LIVE)) |-> $stable(sw_q));

endmodule

// File: rtl/chsel_ctrl.sv
// Top of the serial channel-select controller. Synchronises the serial pins,
// detects edges, runs the command shift register, the switch sequencer and
// the data line direction control.
// Assumes the serial clock is slow enough that each level lasts at least
// three system clock cycles.
module chsel_ctrl
    import chsel_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int T_ON    = 6,
    parameter int T_OFF   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_in,
    input  logic            sel_in,
    input  logic            up_in,
    output logic            up_out,
    output logic            up_oe,
    input  logic            dn_in,
    output logic            dn_out,
    output logic            dn_oe,
    output logic [N_CH-1:0] sw_en
);
    localparam int IDX_W = $clog2(N_CH);
    localparam int CMD_W = IDX_W + 1;

    logic [2:0]       sync_out;
    logic             sclk_s, sel_s, up_s;
    logic             sclk_d, sel_d;
    logic             sclk_rise, sel_rise, sel_fall;
    logic [CMD_W-1:0] cmd_word;
    logic             sr_tail;
    dir_t             dir_q;

    chsel_sync #(.W(3)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({up_in, sel_in, sclk_in}),
        .d_sync  (sync_out)
    );
    assign sclk_s = sync_out[0];
    assign sel_s  = sync_out[1];
    assign up_s   = sync_out[2];

    // Delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sel_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sel_d  <= sel_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sel_rise  = sel_s & ~sel_d;
    assign sel_fall  = ~sel_s & sel_d;

    chsel_shreg #(.W(CMD_W)) i_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise & sel_s),
        .din      (up_s),
        .word     (cmd_word),
        .tail     (sr_tail)
    );

    chsel_switch_seq #(.N_CH(N_CH), .ON_DLY(T_ON), .OFF_DLY(T_OFF)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_fall (sel_fall),
        .sel_rise (sel_rise),
        .cmd      (cmd_word),
        .sw_en    (sw_en)
    );

    // Direction follows select edges; stays undriven until the first frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= DIR_NONE;
        else if (sel_rise)
            dir_q <= DIR_FWD;
        else if (sel_fall)
            dir_q <= DIR_REV;
    end

    assign dn_oe  = (dir_q == DIR_FWD);
    assign up_oe  = (dir_q == DIR_REV);
    assign dn_out = sr_tail;
    assign up_out = dn_in;

    // R6/R7: the two data lines are never driven at the same time
    a_r6_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_oe && dn_oe));

    // R7: a select fall hands the upstream line to the block next cycle
    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fall |=> (up_oe && !dn_oe));

endmodule

// File: tb/test_chsel_ctrl.sv
module test_chsel_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH  = 8;
    localparam int T_ON  = 6;
    localparam int T_OFF = 4;
    localparam int SCLK_HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0, sel_in = 1'b0, up_in = 1'b0, dn_in = 1'b0;
    logic up_out, up_oe, dn_out, dn_oe;
    logic [N_CH-1:0] sw_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [3:0] model_sr = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chsel_ctrl #(.N_CH(N_CH), .T_ON(T_ON), .T_OFF(T_OFF)) i_chsel_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sel_in(sel_in),
        .up_in(up_in), .up_out(up_out), .up_oe(up_oe),
        .dn_in(dn_in), .dn_out(dn_out), .dn_oe(dn_oe), .sw_en(sw_en));

    function automatic logic [N_CH-1:0] exp_sw(input logic [3:0] c);
        exp_sw = c[3] ? (N_CH'(1) << c[2:0]) : '0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        up_in = b; sclk_in = 1'b0; tick(SCLK_HALF);
        sclk_in = 1'b1; tick(SCLK_HALF);
        model_sr = {model_sr[2:0], b};
        check(dn_out == model_sr[3], "R6", "dn_out tail", dn_out, model_sr[3]);
    endtask

    // Raise select and measure when the previous switch opens
    task automatic raise_sel(input logic [N_CH-1:0] prev);
        int first_off = 0;
        sel_in = 1'b1;
        for (int n = 1; n <= T_OFF + 6; n++) begin
            tick(1);
            if (first_off == 0 && sw_en == '0) first_off = n;
            if (first_off == 0) check(sw_en == prev, "R5", "hold during drain", sw_en, prev);
        end
        if (prev != '0)
            check(first_off == T_OFF + 3, "R5", "turn-off edge", first_off, T_OFF + 3);
        check(dn_oe && !up_oe, "R6", "forward direction", {dn_oe, up_oe}, 2'b10);
    endtask

    // Drop select and measure when the selected switch closes
    task automatic drop_sel(input logic [3:0] c);
        int first_on = 0;
        logic [N_CH-1:0] seen = '0;
        logic [N_CH-1:0] exp = exp_sw(c);
        sel_in = 1'b0;
        for (int n = 1; n <= T_ON + 6; n++) begin
            tick(1);
            if (n == 3) check(sw_en == '0, "R4", "all open after fall", sw_en, 0);
            if (first_on == 0 && sw_en != '0) begin first_on = n; seen = sw_en; end
        end
        if (c[3]) begin
            check(first_on == T_ON + 3, "R4", "turn-on edge", first_on, T_ON + 3);
            check(seen == exp, "R3", "selected switch", seen, exp);
        end else
            check(first_on == 0, "R3", "disabled command keeps all open", sw_en, 0);
        check(up_oe && !dn_oe, "R7", "reverse direction", {up_oe, dn_oe}, 2'b10);
        for (int k = 0; k < 2; k++) begin
            dn_in = ~dn_in; #1;
            check(up_out == dn_in, "R7", "combinational pass-back", up_out, dn_in);
        end
    endtask

    // Stay low, toggling sclk with junk data; switches must not move
    task automatic hold_low(input logic [3:0] c, input int cycles);
        logic [N_CH-1:0] exp = exp_sw(c);
        bit ok = 1;
        logic [N_CH-1:0] bad = '0;
        for (int n = 0; n < cycles; n++) begin
            if (n % SCLK_HALF == 0) begin sclk_in = ~sclk_in; up_in = 1'($urandom); end
            tick(1);
            if (sw_en != exp) begin ok = 0; bad = sw_en; end
        end
        sclk_in = 1'b0;
        check(ok, "R5", "stable while select low (R9 sclk ignored)", bad, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [3:0] cmd;
        logic [3:0] last_cmd;
        logic [N_CH-1:0] prev;
        int extra;
        void'($urandom(32'd20240607));
        tick(3);
        // R1: state during reset
        check(sw_en == '0 && !up_oe && !dn_oe && !dn_out, "R1", "in reset",
              {sw_en, up_oe, dn_oe, dn_out}, 0);
        rst_n = 1'b1;
        tick(5);
        check(sw_en == '0 && !up_oe && !dn_oe && !dn_out, "R1", "after reset",
              {sw_en, up_oe, dn_oe, dn_out}, 0);

        prev = '0;
        last_cmd = 4'h0;
        // Directed corners first, then random frames
        for (int f = 0; f < 24; f++) begin
            case (f)
                0: begin cmd = 4'b1000; extra = 0; end   // R3 channel 0
                1: begin cmd = 4'b1111; extra = 0; end   // R3 channel 7
                2: begin cmd = 4'b0101; extra = 0; end   // R3 disabled
                3: begin cmd = 4'b1011; extra = 3; end   // R2 extra bits
                default: begin cmd = 4'($urandom); extra = $urandom_range(0, 2); end
            endcase
            raise_sel(prev);
            tick(2);
            for (int b = 0; b < extra; b++) send_bit(1'($urandom));
            for (int b = 3; b >= 0; b--) send_bit(cmd[b]);
            check(model_sr == cmd, "R2", "last four bits form command", model_sr, cmd);
            drop_sel(cmd);
            hold_low(cmd, $urandom_range(8, 40));
            prev = exp_sw(cmd);
            last_cmd = cmd;
        end

        // R9: an empty frame re-selects the previous command
        raise_sel(prev);
        tick(T_OFF + 2);
        drop_sel(last_cmd);
        check(sw_en == exp_sw(last_cmd), "R9", "empty frame reselects", sw_en, exp_sw(last_cmd));
        tick(5);
        finish_run();
    end
endmodule